// File: doc/BRIEF.md
# Scanline Mode Timing Sequencer

This block paces a tile-based LCD pixel processor. On every dot-clock enable it advances a dot counter through a fixed 456-dot scanline and a line counter through a 154-line frame. From these counters it derives the two-bit display mode: object search, drawing, horizontal blank or vertical blank. Visible lines run search, then draw, then horizontal blank. The last ten lines of the frame are vertical blank.

The drawing phase has a variable length. An external stall calculator supplies that length, and the block captures it on the dot where drawing begins. Horizontal blank takes up whatever remains of the line.

Each mode determines which video memories the CPU may reach. The block turns the current mode into three permission flags. It also applies them in a small bus gate that drops writes to a blocked memory and returns all ones on reads from it. While the display is switched off, the sequencer rests at line 0, dot 0, in mode 0, and every memory is open.

Top module: `lcd_mode_seq`

## Requirements
- R1: The dot counter `dot_o` counts 0 to 455 and then wraps to 0, at which point `ly_o` increments. `ly_o` counts 0 to 153 and then wraps to 0, so one frame is 70224 advancing ticks.
- R2: The mode encoding is 0 = horizontal blank, 1 = vertical blank, 2 = object search, 3 = drawing. On lines 0 to 143, dots 0 to 79 are mode 2, the next L dots are mode 3, and the rest of the line is mode 0, so mode 0 lasts 376 − L dots. On lines 144 to 153 the mode is 1 for the whole line.
- R3: L is taken from `draw_len_i` on the tick that enters dot 80 of a visible line and is held until the next such tick. Values below 172 are raised to 172, and values above 289 are lowered to 289.
- R4: Counters, mode and L change only on a clock where `dot_en_i` is high. When `dot_en_i` is low, state holds and both strobes are low.
- R5: On the clock after `disp_en_i` is seen low, the outputs are `dot_o` = 0, `ly_o` = 0, mode 0, all three permission flags high, and both strobes low. The first enabled tick after that shows dot 0, line 0, mode 2, with both strobes high.
- R6: `mode_chg_o` is high for exactly the one clock after a tick whose new mode differs from the old one. `line_start_o` is high for exactly the one clock after a tick that lands on dot 0.
- R7: `oam_ok_o` is low in modes 2 and 3. `vram_ok_o` and `pal_ok_o` are low in mode 3 only.
- R8: The target encoding of `cpu_tgt_i` is 0 = sprite attribute memory, 1 = video RAM, 2 = palette port, 3 = unrestricted. For a blocked target, `mem_we_o` is 0 and `cpu_rdata_o` is 0xFF. For an open target, `mem_we_o` follows `cpu_we_i` and `cpu_rdata_o` follows `mem_rdata_i`.
- R9: While `rst` is high, the state is the same as with the display off (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en_i | input | 1 | One-clock dot tick enable |
| disp_en_i | input | 1 | Display enable |
| draw_len_i | input | 9 | Drawing-phase length from the stall calculator |
| mode_o | output | 2 | Current mode |
| ly_o | output | 8 | Current line |
| dot_o | output | 9 | Current dot within the line |
| mode_chg_o | output | 1 | Mode transition strobe |
| line_start_o | output | 1 | Line start strobe |
| oam_ok_o | output | 1 | Sprite attribute memory open to the CPU |
| vram_ok_o | output | 1 | Video RAM open to the CPU |
| pal_ok_o | output | 1 | Palette ports open to the CPU |
| cpu_tgt_i | input | 2 | Memory targeted by the CPU access |
| cpu_we_i | input | 1 | CPU write request |
| mem_rdata_i | input | 8 | Read data from the targeted memory |
| mem_we_o | output | 1 | Gated write enable to the memory |
| cpu_rdata_o | output | 8 | Gated read data to the CPU |

## Verification
The assertions assume that `dot_en_i` and `disp_en_i` are synchronous one-clock levels. They accept any value on `draw_len_i`, because the block clamps it.

The stimulus keeps the display on for long stretches, so that full lines and a whole frame can complete. It drives `draw_len_i` with values both inside and outside the legal range, and it changes the value while drawing is in progress to show that it is ignored there. Dropping `disp_en_i` and pulsing `rst` are rare random events, which leaves enough running time between them for each mode sequence to be exercised.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SEARCH = 2'd2,
    MODE_DRAW   = 2'd3
  } lcd_mode_e;

  typedef enum logic [1:0] {
    TGT_OAM  = 2'd0,
    TGT_VRAM = 2'd1,
    TGT_PAL  = 2'd2,
    TGT_FREE = 2'd3
  } cpu_tgt_e;

  typedef struct packed {
    logic oam;
    logic vram;
    logic pal;
  } access_t;
endpackage

// File: rtl/lms_counters.sv
module lms_counters #(
  parameter int DOTS  = 456,
  parameter int LINES = 154,
  parameter int DW    = $clog2(DOTS),
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dot_en,
  input  logic          disp_en,
  output logic          step,
  output logic [DW-1:0] dot_n,
  output logic [LW-1:0] line_n,
  output logic [DW-1:0] dot_q,
  output logic [LW-1:0] line_q
);
  localparam logic [DW-1:0] DOT_LAST  = DW'(DOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

  logic running_q;

  assign step = disp_en & dot_en;

  // Next position: the first tick after enable lands on dot 0 of line 0.
  always_comb begin
    dot_n  = '0;
    line_n = '0;
    if (running_q) begin
      if (dot_q == DOT_LAST) begin
        dot_n  = '0;
        line_n = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
      end else begin
        dot_n  = dot_q + 1'b1;
        line_n = line_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !disp_en) begin
      dot_q     <= '0;
      line_q    <= '0;
      running_q <= 1'b0;
    end else if (dot_en) begin
      dot_q     <= dot_n;
      line_q    <= line_n;
      running_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lms_mode_ctl.sv
module lms_mode_ctl
  import lms_pkg::*;
#(
  parameter int VIS_LINES = 144,
  parameter int SCAN_DOTS = 80,
  parameter int DRAW_MIN  = 172,
  parameter int DRAW_MAX  = 289,
  parameter int DW        = 9,
  parameter int LW        = 8,
  parameter int LENW      = $clog2(DRAW_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            disp_en,
  input  logic            step,
  input  logic [DW-1:0]   dot_n,
  input  logic [LW-1:0]   line_n,
  input  logic [LENW-1:0] draw_len,
  output lcd_mode_e       mode_q,
  output logic            chg_q,
  output logic            lstb_q,
  output access_t         acc_q
);
  localparam int SW = ((DW > LENW) ? DW : LENW) + 1;
  localparam logic [LW-1:0]   VIS_L  = LW'(VIS_LINES);
  localparam logic [SW-1:0]   SCAN_S = SW'(SCAN_DOTS);
  localparam logic [LENW-1:0] MIN_L  = LENW'(DRAW_MIN);
  localparam logic [LENW-1:0] MAX_L  = LENW'(DRAW_MAX);

  logic [LENW-1:0] len_q;
  logic [LENW-1:0] len_clamped;
  logic [LENW-1:0] len_now;
  logic            draw_entry;
  logic [SW-1:0]   dot_w;
  logic [SW-1:0]   draw_end;
  lcd_mode_e       mode_n;
  access_t         acc_n;

  always_comb begin
    if (draw_len < MIN_L)      len_clamped = MIN_L;
    else if (draw_len > MAX_L) len_clamped = MAX_L;
    else                       len_clamped = draw_len;
  end

  assign dot_w      = SW'(dot_n);
  assign draw_entry = (line_n < VIS_L) && (dot_w == SCAN_S);
  assign len_now    = draw_entry ? len_clamped : len_q;
  assign draw_end   = SCAN_S + SW'(len_now);

  always_comb begin
    if (line_n >= VIS_L)      mode_n = MODE_VBLANK;
    else if (dot_w < SCAN_S)  mode_n = MODE_SEARCH;
    else if (dot_w < draw_end) mode_n = MODE_DRAW;
    else                      mode_n = MODE_HBLANK;
  end

  always_comb begin
    acc_n.oam  = (mode_n != MODE_SEARCH) && (mode_n != MODE_DRAW);
    acc_n.vram = (mode_n != MODE_DRAW);
    acc_n.pal  = (mode_n != MODE_DRAW);
  end

  always_ff @(posedge clk) begin
    if (rst || !disp_en) begin
      mode_q <= MODE_HBLANK;
      chg_q  <= 1'b0;
      lstb_q <= 1'b0;
      acc_q  <= '{oam: 1'b1, vram: 1'b1, pal: 1'b1};
      len_q  <= MIN_L;
    end else if (step) begin
      mode_q <= mode_n;
      chg_q  <= (mode_n != mode_q);
      lstb_q <= (dot_n == '0);
      acc_q  <= acc_n;
      if (draw_entry) len_q <= len_clamped;
    end else begin
      chg_q  <= 1'b0;
      lstb_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lms_bus_gate.sv
module lms_bus_gate
  import lms_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  access_t           acc,
  input  logic [1:0]        cpu_tgt,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic allow;

  always_comb begin
    unique case (cpu_tgt_e'(cpu_tgt))
      TGT_OAM:  allow = acc.oam;
      TGT_VRAM: allow = acc.vram;
      TGT_PAL:  allow = acc.pal;
      default:  allow = 1'b1;
    endcase
  end

  assign mem_we    = cpu_we & allow;
  assign cpu_rdata = allow ? mem_rdata : {DATA_W{1'b1}};
endmodule

// File: rtl/lcd_mode_seq.sv
module lcd_mode_seq
  import lms_pkg::*;
#(
  parameter int DOTS_PER_LINE = 456,
  parameter int VIS_LINES     = 144,
  parameter int TOTAL_LINES   = 154,
  parameter int SCAN_DOTS     = 80,
  parameter int DRAW_MIN      = 172,
  parameter int DRAW_MAX      = 289,
  parameter int DATA_W        = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              dot_en_i,
  input  logic                              disp_en_i,
  input  logic [$clog2(DRAW_MAX+1)-1:0]     draw_len_i,
  output logic [1:0]                        mode_o,
  output logic [$clog2(TOTAL_LINES)-1:0]    ly_o,
  output logic [$clog2(DOTS_PER_LINE)-1:0]  dot_o,
  output logic                              mode_chg_o,
  output logic                              line_start_o,
  output logic                              oam_ok_o,
  output logic                              vram_ok_o,
  output logic                              pal_ok_o,
  input  logic [1:0]                        cpu_tgt_i,
  input  logic                              cpu_we_i,
  input  logic [DATA_W-1:0]                 mem_rdata_i,
  output logic                              mem_we_o,
  output logic [DATA_W-1:0]                 cpu_rdata_o
);
  localparam int DW   = $clog2(DOTS_PER_LINE);
  localparam int LW   = $clog2(TOTAL_LINES);
  localparam int LENW = $clog2(DRAW_MAX + 1);

  logic          step;
  logic [DW-1:0] dot_n;
  logic [LW-1:0] line_n;
  lcd_mode_e     mode_q;
  access_t       acc_q;

  lms_counters #(
    .DOTS (DOTS_PER_LINE),
    .LINES(TOTAL_LINES),
    .DW   (DW),
    .LW   (LW)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .dot_en (dot_en_i),
    .disp_en(disp_en_i),
    .step   (step),
    .dot_n  (dot_n),
    .line_n (line_n),
    .dot_q  (dot_o),
    .line_q (ly_o)
  );

  lms_mode_ctl #(
    .VIS_LINES(VIS_LINES),
    .SCAN_DOTS(SCAN_DOTS),
    .DRAW_MIN (DRAW_MIN),
    .DRAW_MAX (DRAW_MAX),
    .DW       (DW),
    .LW       (LW),
    .LENW     (LENW)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .disp_en (disp_en_i),
    .step    (step),
    .dot_n   (dot_n),
    .line_n  (line_n),
    .draw_len(draw_len_i),
    .mode_q  (mode_q),
    .chg_q   (mode_chg_o),
    .lstb_q  (line_start_o),
    .acc_q   (acc_q)
  );

  lms_bus_gate #(
    .DATA_W(DATA_W)
  ) u_gate (
    .acc      (acc_q),
    .cpu_tgt  (cpu_tgt_i),
    .cpu_we   (cpu_we_i),
    .mem_rdata(mem_rdata_i),
    .mem_we   (mem_we_o),
    .cpu_rdata(cpu_rdata_o)
  );

  assign mode_o    = mode_q;
  assign oam_ok_o  = acc_q.oam;
  assign vram_ok_o = acc_q.vram;
  assign pal_ok_o  = acc_q.pal;
endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
  parameter int DOTS_PER_LINE = 456,
  parameter int VIS_LINES     = 144,
  parameter int TOTAL_LINES   = 154,
  parameter int SCAN_DOTS     = 80,
  parameter int DRAW_MAX      = 289,
  parameter int DATA_W        = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              dot_en_i,
  input logic                              disp_en_i,
  input logic [1:0]                        mode_o,
  input logic [$clog2(TOTAL_LINES)-1:0]    ly_o,
  input logic [$clog2(DOTS_PER_LINE)-1:0]  dot_o,
  input logic                              line_start_o,
  input logic                              oam_ok_o,
  input logic                              vram_ok_o,
  input logic                              pal_ok_o,
  input logic [1:0]                        cpu_tgt_i,
  input logic                              mem_we_o,
  input logic [DATA_W-1:0]                 cpu_rdata_o
);
  assert_dot_range_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(dot_o) < DOTS_PER_LINE) && (int'(ly_o) < TOTAL_LINES));

  assert_vblank_lines_R2: assert property (@(posedge clk) disable iff (rst)
    (int'(ly_o) >= VIS_LINES) |-> (mode_o == 2'd1));

  assert_draw_window_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3) |-> ((int'(dot_o) >= SCAN_DOTS) && (int'(dot_o) < SCAN_DOTS + DRAW_MAX)));

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (!dot_en_i && disp_en_i) |=> ($stable(dot_o) && $stable(ly_o) && $stable(mode_o)));

  assert_off_state_R5: assert property (@(posedge clk) disable iff (rst)
    !disp_en_i |=> (mode_o == 2'd0 && ly_o == '0 && dot_o == '0 && oam_ok_o && vram_ok_o && pal_ok_o));

  assert_line_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> (dot_o == '0));

  assert_draw_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3) |-> (!oam_ok_o && !vram_ok_o && !pal_ok_o));

  assert_search_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |-> (!oam_ok_o && vram_ok_o && pal_ok_o));

  assert_gate_vram_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_tgt_i == 2'd1 && !vram_ok_o) |-> (!mem_we_o && cpu_rdata_o == {DATA_W{1'b1}}));
endmodule

bind lcd_mode_seq lms_checker #(
  .DOTS_PER_LINE(DOTS_PER_LINE),
  .VIS_LINES    (VIS_LINES),
  .TOTAL_LINES  (TOTAL_LINES),
  .SCAN_DOTS    (SCAN_DOTS),
  .DRAW_MAX     (DRAW_MAX),
  .DATA_W       (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dot_en_i    (dot_en_i),
  .disp_en_i   (disp_en_i),
  .mode_o      (mode_o),
  .ly_o        (ly_o),
  .dot_o       (dot_o),
  .line_start_o(line_start_o),
  .oam_ok_o    (oam_ok_o),
  .vram_ok_o   (vram_ok_o),
  .pal_ok_o    (pal_ok_o),
  .cpu_tgt_i   (cpu_tgt_i),
  .mem_we_o    (mem_we_o),
  .cpu_rdata_o (cpu_rdata_o)
);

// File: tb/tb_lcd_mode_seq.sv
`timescale 1ns/1ps
module tb_lcd_mode_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dot_en = 1'b0;
  logic       disp_en = 1'b0;
  logic [8:0] draw_len = 9'd172;
  logic [1:0] mode;
  logic [7:0] ly;
  logic [8:0] dot;
  logic       mode_chg, line_start, oam_ok, vram_ok, pal_ok;
  logic [1:0] cpu_tgt = 2'd3;
  logic       cpu_we = 1'b0;
  logic [7:0] mem_rdata = 8'h00;
  logic       mem_we;
  logic [7:0] cpu_rdata;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lcd_mode_seq dut (
    .clk(clk), .rst(rst), .dot_en_i(dot_en), .disp_en_i(disp_en),
    .draw_len_i(draw_len), .mode_o(mode), .ly_o(ly), .dot_o(dot),
    .mode_chg_o(mode_chg), .line_start_o(line_start),
    .oam_ok_o(oam_ok), .vram_ok_o(vram_ok), .pal_ok_o(pal_ok),
    .cpu_tgt_i(cpu_tgt), .cpu_we_i(cpu_we), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .cpu_rdata_o(cpu_rdata)
  );

  function automatic int clampf(int v);
    if (v < 172) return 172;
    if (v > 289) return 289;
    return v;
  endfunction

  function automatic int exp_mode(int d, int l, int len);
    if (l >= 144) return 1;
    if (d < 80) return 2;
    if (d < 80 + len) return 3;
    return 0;
  endfunction

  function automatic int pattern_len(int l);
    case (l % 4)
      0: return 172;
      1: return 289;
      2: return 100;
      default: return 400;
    endcase
  endfunction

  // Reference state, updated on each rising edge from the bench's own inputs.
  int m_dot = 0, m_line = 0, m_len = 172, m_mode = 0;
  bit m_run = 0, m_chg = 0, m_ls = 0;
  int nd, nl, nm;

  always @(posedge clk) begin
    if (rst || !disp_en) begin
      m_run = 0; m_dot = 0; m_line = 0; m_len = 172;
      m_mode = 0; m_chg = 0; m_ls = 0;
    end else if (dot_en) begin
      if (m_run) begin
        nd = m_dot + 1; nl = m_line;
        if (nd == 456) begin nd = 0; nl = (m_line + 1) % 154; end
      end else begin
        nd = 0; nl = 0;
      end
      if (nl < 144 && nd == 80) m_len = clampf(int'(draw_len));
      nm = exp_mode(nd, nl, m_len);
      m_chg = (nm != m_mode);
      m_ls = (nd == 0);
      m_mode = nm; m_dot = nd; m_line = nl; m_run = 1;
    end else begin
      m_chg = 0; m_ls = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_state();
    chk(int'(dot) == m_dot, "R1 dot", int'(dot), m_dot);
    chk(int'(ly) == m_line, "R1 line", int'(ly), m_line);
    chk(int'(mode) == m_mode, "R2 mode", int'(mode), m_mode);
    chk(mode_chg == m_chg, "R6 mode_chg", int'(mode_chg), int'(m_chg));
    chk(line_start == m_ls, "R6 line_start", int'(line_start), int'(m_ls));
    chk({oam_ok, vram_ok, pal_ok} ==
        {(m_mode != 2 && m_mode != 3), (m_mode != 3), (m_mode != 3)},
        "R7 access", int'({oam_ok, vram_ok, pal_ok}),
        int'({(m_mode != 2 && m_mode != 3), (m_mode != 3), (m_mode != 3)}));
  endtask

  task automatic gate_check();
    bit ok;
    cpu_tgt   = 2'($urandom % 4);
    cpu_we    = 1'($urandom % 2);
    mem_rdata = 8'($urandom % 256);
    #1;
    case (cpu_tgt)
      2'd0: ok = (m_mode != 2 && m_mode != 3);
      2'd1, 2'd2: ok = (m_mode != 3);
      default: ok = 1;
    endcase
    chk(mem_we == (cpu_we & ok), "R8 mem_we", int'(mem_we), int'(cpu_we & ok));
    chk(cpu_rdata == (ok ? mem_rdata : 8'hFF), "R8 rdata", int'(cpu_rdata),
        int'(ok ? mem_rdata : 8'hFF));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  int cnt3, cnt0, ls_count;

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(mode == 2'd0 && ly == 0 && dot == 0, "R9 reset position", int'(mode), 0);
    chk(oam_ok && vram_ok && pal_ok && !mode_chg && !line_start, "R9 reset flags",
        int'({oam_ok, vram_ok, pal_ok}), 7);
    rst = 1'b0;
    @(negedge clk);
    compare_state();

    // Phase A: one full frame at one tick per clock.
    disp_en = 1'b1; dot_en = 1'b1;
    cnt3 = 0; cnt0 = 0; ls_count = 0;
    for (int i = 0; i <= 70224; i++) begin
      @(negedge clk);
      compare_state();
      if (i == 0) chk(mode == 2'd2 && line_start && mode_chg, "R5 first tick", int'(mode), 2);
      if (i > 0 && line_start) ls_count++;
      if (dot == 0) begin cnt3 = 0; cnt0 = 0; end
      if (mode == 2'd3) cnt3++;
      if (mode == 2'd0) cnt0++;
      if (dot == 9'd455 && ly < 8'd144) begin
        chk(cnt3 == clampf(pattern_len(int'(ly))), "R3 draw length", cnt3,
            clampf(pattern_len(int'(ly))));
        chk(cnt0 == 376 - clampf(pattern_len(int'(ly))), "R2 hblank length", cnt0,
            376 - clampf(pattern_len(int'(ly))));
      end
      gate_check();
      // Supply the pattern just before dot 80; garbage otherwise (held value must win).
      if (m_dot == 79 && m_line < 144) draw_len = 9'(pattern_len(m_line));
      else draw_len = 9'($urandom % 512);
    end
    chk(ls_count == 154, "R1 lines per frame", ls_count, 154);
    chk(dot == 0 && ly == 0, "R1 frame wrap", int'(ly), 0);

    // Phase C: directed disable during drawing, hold while idle, re-enable.
    while (!(m_mode == 3)) begin @(negedge clk); compare_state(); end
    disp_en = 1'b0;
    @(negedge clk);
    compare_state();
    chk(mode == 2'd0 && oam_ok && vram_ok && pal_ok, "R5 display off", int'(mode), 0);
    disp_en = 1'b1; dot_en = 1'b0;
    repeat (4) begin
      @(negedge clk);
      compare_state();
      chk(mode == 2'd0 && dot == 0 && !line_start, "R4 no tick hold", int'(mode), 0);
    end
    dot_en = 1'b1;
    @(negedge clk);
    compare_state();
    chk(mode == 2'd2 && line_start && mode_chg, "R5 restart", int'(mode), 2);

    // Phase B: random ticks, lengths, rare disables and resets.
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      compare_state();
      gate_check();
      dot_en   = ($urandom % 10) < 7;
      draw_len = 9'($urandom % 512);
      if (!disp_en) disp_en = ($urandom % 4) == 0;
      else disp_en = ($urandom % 3000) != 0;
      rst = ($urandom % 10000) == 0;
    end
    rst = 1'b0;
    finish_run();
  end
endmodule